// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Selector

This block sits in a clock generator at the point where a handful of package pins have two lives. While the power-on reset is held, those pins are inputs whose board-level pull resistors encode a 4-bit frequency code and a mode bit. On the first clock edge after reset is released, the levels are captured into a latch. One cycle later the pins are handed over to their clock drivers through output-enable controls.

After start-up, the active frequency code comes from one of two sources. Either the captured straps are used, or a 4-bit code assembled from a configuration byte. An override bit in that byte picks the source, and it may be changed at any time. For the active code, the block reports the CPU-to-PCI divide ratio, which is 2, 3 or 4. It runs a counter with that ratio and produces a one-cycle tick at each divider boundary. A new code is applied only at such a boundary, and a one-cycle flag marks when that happens. The captured mode bit decides whether a shared reference-clock pin stays an output or becomes the PCI stop input. The configuration byte also carries an output tristate bit and the spread-spectrum controls, which are passed on as decoded signals.

Top module: `strapFselTop`

## Requirements
- R1: While porN is low: pinOe is all zeros, refOe, pciStopSel, pciTick and codeChanged are 0, codeOut is 0000, and latchedCode is 0000.
- R2: On the first rising clk edge with porN high, strapIn is copied to latchedCode and modeIn is captured. Later changes on strapIn or modeIn do not change latchedCode or the mode decode.
- R3: Every bit of pinOe goes high on the second rising edge after porN is released, which is one cycle after capture, and stays high while cfgByte0 bit 0 is 0.
- R4: After start-up, a captured mode of 0 gives pciStopSel=1 and refOe=0. A captured mode of 1 gives pciStopSel=0 and refOe=1.
- R5: cfgByte0 bit 3 = 0 selects latchedCode as the active code. Bit 3 = 1 selects the register code {bit2, bit6, bit5, bit4}, with bit 2 as the most significant bit.
- R6: pciDiv is 4 for codes 1100 to 1111, 3 for codes 0100 to 1011 and for code 0000, and 2 for codes 0001 to 0011.
- R7: On the edge that starts operation, codeOut loads the selected code. Later changes to the selected code reach codeOut only on an edge where pciTick is high, and codeChanged is then high for exactly the following cycle.
- R8: Starting with the first cycle of operation, pciTick is high in cycle pciDiv-1 and then in every pciDiv-th cycle after it.
- R9: cfgByte0 bit 0 = 1 forces every bit of pinOe and refOe low and sets outTristate. Clearing the bit restores them.
- R10: spreadEn follows cfgByte0 bit 1, and spreadCenter follows cfgByte0 bit 7 (0 = down-spread, 1 = center-spread).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| porN | input | 1 | Active-low power-on reset, asynchronous assert |
| strapIn | input | 4 | Raw frequency strap levels |
| modeIn | input | 1 | Raw mode strap level |
| cfgByte0 | input | 8 | Configuration byte: override, register code, spread, tristate |
| latchedCode | output | 4 | Captured strap code |
| codeOut | output | 4 | Applied frequency code |
| pciDiv | output | 3 | CPU-to-PCI divide ratio for codeOut |
| pciTick | output | 1 | Divider boundary tick |
| codeChanged | output | 1 | One-cycle pulse after a code update |
| pinOe | output | 5 | Output enables of the four frequency straps and the mode strap pin |
| refOe | output | 1 | Output enable of the shared reference pin |
| pciStopSel | output | 1 | Shared reference pin used as the PCI stop input |
| outTristate | output | 1 | All-outputs tristate request |
| spreadEn | output | 1 | Spread spectrum enable |
| spreadCenter | output | 1 | Spread mode select: 0 = down-spread, 1 = center-spread |

## Verification
The assertions check, on every cycle, these invariants: the divide ratio is always legal, the counter stays below the ratio, the latch does not move once running, output enables rise only right after the start strobe, and every codeChanged pulse is single and follows a tick. Some properties need a reference computed from the stimulus, and only the bench scenarios show them. These are: the latched value against the driven straps, the assembled register bit order, the full divide-ratio map, the exact tick period, and the deferral of a code change to the next boundary. The bench sweeps all sixteen strap codes and all sixteen register codes to cover them.

// File: rtl/strapFselPkg.sv
package strapFselPkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic capture;
    logic start;
    logic running;
  } ctrlStrb_t;

  function automatic logic [2:0] divForCode(input logic [CODE_W-1:0] c);
    logic [2:0] d;
    if (c[3:2] == 2'b11)      d = 3'd4;
    else if (c[3:2] != 2'b00) d = 3'd3;
    else if (c == 4'b0000)    d = 3'd3;
    else                      d = 3'd2;
    return d;
  endfunction
endpackage

// File: rtl/strapCtrl.sv
module strapCtrl import strapFselPkg::*; #(
  parameter int PIN_CNT = 5
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               tristate,
  input  logic               modeLatched,
  output ctrlStrb_t          strb,
  output logic [PIN_CNT-1:0] pinOe,
  output logic               refOe,
  output logic               pciStopSel
);
  typedef enum logic [1:0] {S_WAIT, S_CAP, S_RUN} phase_t;
  phase_t phase;
  logic   oeState;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phase   <= S_WAIT;
      oeState <= 1'b0;
    end else begin
      case (phase)
        S_WAIT:  phase <= S_CAP;
        S_CAP:   phase <= S_RUN;
        default: phase <= S_RUN;
      endcase
      if (strb.start) oeState <= 1'b1;
    end
  end

  always_comb begin
    strb.capture = (phase == S_WAIT);
    strb.start   = (phase == S_CAP);
    strb.running = (phase == S_RUN);
  end

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_oe
    assign pinOe[g] = oeState & ~tristate;
  end

  assign refOe      = oeState & modeLatched & ~tristate;
  assign pciStopSel = oeState & ~modeLatched;

  // R3: enables rise only right after the start strobe
  p_oe_after_start_r3: assert property (@(posedge clk) disable iff (!porN)
    $rose(oeState) |-> $past(strb.start));
  // R4: the two uses of the shared pin never coexist
  p_ref_excl_r4: assert property (@(posedge clk) disable iff (!porN)
    !(refOe && pciStopSel));
endmodule

// File: rtl/fselDatapath.sv
module fselDatapath import strapFselPkg::*; #(
  parameter int MAX_DIV = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrb_t         strb,
  input  logic [CODE_W-1:0] strapIn,
  input  logic              modeIn,
  input  logic              regOvr,
  input  logic [CODE_W-1:0] regCode,
  output logic [CODE_W-1:0] latchedCode,
  output logic              modeLatched,
  output logic [CODE_W-1:0] codeOut,
  output logic [2:0]        pciDiv,
  output logic              pciTick,
  output logic              codeChanged
);
  localparam int CNT_W = $clog2(MAX_DIV);
  localparam int DIV_W = 3;

  logic [CODE_W-1:0] selCode;
  logic [CNT_W-1:0]  cnt;

  assign selCode = regOvr ? regCode : latchedCode;
  assign pciDiv  = divForCode(codeOut);
  assign pciTick = strb.running && (DIV_W'(cnt) == pciDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      latchedCode <= '0;
      modeLatched <= 1'b1;
      codeOut     <= '0;
      cnt         <= '0;
      codeChanged <= 1'b0;
    end else begin
      codeChanged <= 1'b0;
      if (strb.capture) begin
        latchedCode <= strapIn;
        modeLatched <= modeIn;
      end
      if (strb.start) begin
        codeOut <= selCode;
        cnt     <= '0;
      end else if (strb.running) begin
        if (pciTick) begin
          cnt <= '0;
          if (selCode != codeOut) begin
            codeOut     <= selCode;
            codeChanged <= 1'b1;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R2: latch frozen once running
  p_latch_frozen_r2: assert property (@(posedge clk) disable iff (!porN)
    strb.running |=> $stable(latchedCode));
  // R6: only legal ratios
  p_div_legal_r6: assert property (@(posedge clk) disable iff (!porN)
    (pciDiv == 3'd2) || (pciDiv == 3'd3) || (pciDiv == 3'd4));
  // R7: a change pulse follows a tick and lasts one cycle
  p_change_on_tick_r7: assert property (@(posedge clk) disable iff (!porN)
    codeChanged |-> $past(pciTick));
  p_change_single_r7: assert property (@(posedge clk) disable iff (!porN)
    codeChanged |=> !codeChanged);
  // R8: counter stays inside the ratio
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!porN)
    DIV_W'(cnt) < pciDiv);
endmodule

// File: rtl/strapFselTop.sv
module strapFselTop import strapFselPkg::*; #(
  parameter int PIN_CNT = 5,
  parameter int MAX_DIV = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [3:0]         strapIn,
  input  logic               modeIn,
  input  logic [7:0]         cfgByte0,
  output logic [3:0]         latchedCode,
  output logic [3:0]         codeOut,
  output logic [2:0]         pciDiv,
  output logic               pciTick,
  output logic               codeChanged,
  output logic [PIN_CNT-1:0] pinOe,
  output logic               refOe,
  output logic               pciStopSel,
  output logic               outTristate,
  output logic               spreadEn,
  output logic               spreadCenter
);
  ctrlStrb_t strb;
  logic      modeLatched;

  strapCtrl #(.PIN_CNT(PIN_CNT)) u_ctrl (
    .clk(clk), .porN(porN), .tristate(cfgByte0[0]), .modeLatched(modeLatched),
    .strb(strb), .pinOe(pinOe), .refOe(refOe), .pciStopSel(pciStopSel)
  );

  fselDatapath #(.MAX_DIV(MAX_DIV)) u_dp (
    .clk(clk), .porN(porN), .strb(strb), .strapIn(strapIn), .modeIn(modeIn),
    .regOvr(cfgByte0[3]),
    .regCode({cfgByte0[2], cfgByte0[6], cfgByte0[5], cfgByte0[4]}),
    .latchedCode(latchedCode), .modeLatched(modeLatched), .codeOut(codeOut),
    .pciDiv(pciDiv), .pciTick(pciTick), .codeChanged(codeChanged)
  );

  assign outTristate  = cfgByte0[0];
  assign spreadEn     = cfgByte0[1];
  assign spreadCenter = cfgByte0[7];
endmodule

// File: tb/sim_strapFselTop.sv
module sim_strapFselTop;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [3:0] strapIn = '0;
  logic       modeIn = 1'b1;
  logic [7:0] cfgByte0 = '0;
  logic [3:0] latchedCode, codeOut;
  logic [2:0] pciDiv;
  logic       pciTick, codeChanged, refOe, pciStopSel, outTristate, spreadEn, spreadCenter;
  logic [4:0] pinOe;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  strapFselTop u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expDiv(input int c);
    if (c >= 12) return 4;
    if (c >= 4) return 3;
    if (c == 0) return 3;
    return 2;
  endfunction

  function automatic logic [7:0] mkCfg(input logic [3:0] c, input bit ovr,
                                       input bit spr, input bit ctr, input bit tri3);
    return {ctr, c[2], c[1], c[0], ovr, c[3], spr, tri3};
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  // Boot: ends at the negedge after the start edge (first running cycle).
  task automatic boot(input logic [3:0] s, input logic m, input logic [7:0] c, input bit checkReset);
    @(negedge clk);
    porN = 1'b0; strapIn = s; modeIn = m; cfgByte0 = c;
    repeat (2) @(negedge clk);
    if (checkReset) begin
      chk(pinOe == 0, "R1 pinOe", pinOe, 0);
      chk(codeOut == 0 && latchedCode == 0, "R1 codes", codeOut, 0);
      chk(!refOe && !pciStopSel && !pciTick && !codeChanged, "R1 ctl", refOe, 0);
    end
    porN = 1'b1;
    @(negedge clk);
    chk(latchedCode == s, "R2 capture", latchedCode, s);
    chk(pinOe == 0, "R3 oe not yet", pinOe, 0);
    strapIn = ~s; modeIn = ~m;
    @(negedge clk);
  endtask

  initial begin
    boot(4'b0101, 1'b1, 8'h00, 1'b1);
    chk(pinOe == 5'h1f, "R3 oe on", pinOe, 31);

    // Sweep strap codes: capture, ratio, tick period
    for (int s = 0; s < 16; s++) begin
      boot(4'(s), 1'b1, 8'h00, 1'b0);
      chk(codeOut == 4'(s), "R5 strap source", codeOut, s);
      chk(int'(pciDiv) == expDiv(s), "R6 ratio", pciDiv, expDiv(s));
      for (int i = 0; i < 2 * expDiv(s); i++) begin
        chk(pciTick == ((i % expDiv(s)) == expDiv(s) - 1), "R8 tick", pciTick,
            int'((i % expDiv(s)) == expDiv(s) - 1));
        @(negedge clk);
      end
      chk(latchedCode == 4'(s), "R2 straps ignored", latchedCode, s);
    end

    // Mode strap
    boot(4'b0111, 1'b0, 8'h00, 1'b0);
    chk(pciStopSel && !refOe, "R4 mode0", pciStopSel, 1);
    boot(4'b0111, 1'b1, 8'h00, 1'b0);
    chk(!pciStopSel && refOe, "R4 mode1", refOe, 1);

    // Register override sweep with deferral to boundary
    begin
      logic [3:0] cur;
      boot(4'b0101, 1'b1, 8'h00, 1'b0);
      cur = 4'b0101;
      for (int rc = 15; rc >= 0; rc--) begin
        bit prevTick;
        bit seen;
        cfgByte0 = mkCfg(4'(rc), 1'b1, 1'b0, 1'b0, 1'b0);
        prevTick = pciTick;
        seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
          @(negedge clk);
          if (codeChanged) begin
            seen = 1'b1;
            chk(prevTick, "R7 after tick", prevTick, 1);
            chk(codeOut == 4'(rc), "R5 reg code", codeOut, rc);
            @(negedge clk);
            chk(!codeChanged, "R7 one cycle", codeChanged, 0);
          end else begin
            chk(codeOut == cur, "R7 held", codeOut, cur);
          end
          prevTick = pciTick;
        end
        chk(seen == (4'(rc) != cur), "R7 pulse", seen, int'(4'(rc) != cur));
        cur = 4'(rc);
      end
      // back to straps
      cfgByte0 = 8'h00;
      repeat (6) @(negedge clk);
      chk(codeOut == 4'b0101, "R5 back to straps", codeOut, 5);
    end

    // Tristate and spread
    cfgByte0 = mkCfg(4'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    chk(pinOe == 0 && !refOe && outTristate, "R9 tristate", pinOe, 0);
    cfgByte0 = 8'h00;
    #1;
    chk(pinOe == 5'h1f && refOe && !outTristate, "R9 restore", pinOe, 31);
    cfgByte0 = mkCfg(4'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    #1;
    chk(spreadEn && !spreadCenter, "R10 down", spreadEn, 1);
    cfgByte0 = mkCfg(4'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    #1;
    chk(spreadEn && spreadCenter, "R10 center", spreadCenter, 1);
    cfgByte0 = 8'h00;
    #1;
    chk(!spreadEn && !spreadCenter, "R10 off", spreadEn, 0);

    finishRun();
  end
endmodule